// File: doc/BRIEF.md
# Hardware Reset Pulse Controller

This block handles the external active-low reset pin of a memory device's internal controller. It passes the pin through a short synchroniser chain. It then measures how long the pin stays low. Only a low pulse that reaches a minimum width counts as a reset. A valid reset aborts any program or erase that is running and holds the internal state machine in reset until a ready interval, counted from the synchronised falling edge, has run out.

While the pin is low, the data outputs are kept disabled and the ready/busy indication is flagged as meaningless. After the pin is released, reads stay blocked for a further recovery interval. If a program or erase was running when the reset was honoured, a flag reports that the addressed location is now corrupt.

A low pulse shorter than the minimum changes no internal state. It only disables the outputs while the synchronised pin is low. A new low pulse during recovery returns the block directly to the held state.

Top module: `rst_pulse_ctl`

## Requirements
- R1: In the edge counts below, edge 1 is the first rising clock edge that samples the pin low. The pin counts as a valid reset when it is sampled low at TRP consecutive rising edges, and no fewer.
- R2: A valid reset raises `abortOp` for exactly one cycle, starting right after edge TRP+2.
- R3: `smReset` rises after edge TRP+2 of a valid reset. It stays high through edge TREADY+1 and is low after edge TREADY+2.
- R4: `dqOeAllow` is low from edge 2 of a low pulse until one edge after the first edge that samples the pin high. After that edge it is high again.
- R5: After a valid reset, `readAllow` rises after edge max(Hr+TRH+2, TREADY+3), where Hr is the index of the first edge that samples the pin high. Before that edge it is low.
- R6: `readyMasked` is high whenever `dqOeAllow` is low, and also while `smReset` is high.
- R7: On a valid reset, `corruptFlag` takes the value `opBusy` had at edge TRP+2. It changes at no other time.
- R8: A pulse sampled low at fewer than TRP edges is ignored. It gives no `abortOp`, leaves `corruptFlag` unchanged, and `readAllow` is high again one edge after the pin is sampled high.
- R9: After `rst_n` is released, `readAllow` and `dqOeAllow` are high and `abortOp`, `smReset`, `readyMasked` and `corruptFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| resetPinN | input | 1 | External active-low reset pin (asynchronous) |
| opBusy | input | 1 | A program or erase is in progress |
| abortOp | output | 1 | One-cycle pulse that terminates the running operation |
| smReset | output | 1 | Holds the internal state machine in reset |
| dqOeAllow | output | 1 | Data outputs may drive (low means tri-stated) |
| readAllow | output | 1 | Read access is permitted |
| readyMasked | output | 1 | The ready/busy indication is invalid |
| corruptFlag | output | 1 | The last honoured reset cut a program or erase |

## Verification
The assertions check cycle-level relations on every cycle:
- an abort is a single-cycle pulse, and it only comes once the low count has reached the minimum;
- an abort always coincides with the state-machine reset and with blocked reads;
- the ready/busy mask covers every cycle with the outputs disabled;
- the corrupt flag moves only on an abort.

Exact edge positions can only be shown by the bench scenarios. These cover the qualification boundary at TRP-1 against TRP low edges, and the release delay when it is set by the recovery count and when it is set by the ready count. They also cover the value captured into the corrupt flag.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HELD    = 2'd1,
    ST_RECOVER = 2'd2
  } rstState_e;

  typedef struct packed {
    logic capture;  // valid reset honoured this cycle
    logic clrRec;   // restart the recovery count
  } ctlStrobe_t;
endpackage

// File: rtl/rpc_datapath.sv
module rpc_datapath
  import rpc_pkg::*;
#(
  parameter int TRP         = 4,
  parameter int TREADY      = 10,
  parameter int TRH         = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resetPinN,
  input  logic       opBusy,
  input  ctlStrobe_t strobe,
  output logic       syncLow,
  output logic       qualify,
  output logic       readyDone,
  output logic       recDone,
  output logic       abortOp,
  output logic       corruptFlag,
  output logic       dqOeAllow
);
  localparam int LW = $clog2(TRP + 1);
  localparam int RW = $clog2(TREADY + 1);
  localparam int HW = $clog2(TRH + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [LW-1:0] lowCnt;
  logic [RW-1:0] readyCnt;
  logic [HW-1:0] recCnt;

  // synchroniser chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syncChain[i] <= 1'b1;
      else if (i == 0) syncChain[i] <= resetPinN;
      else syncChain[i] <= syncChain[(i == 0) ? 0 : i-1];
    end
  end

  assign syncLow = ~syncChain[SYNC_STAGES-1];

  // width of the current low pulse, saturating at TRP
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowCnt <= '0;
    else if (!syncLow) lowCnt <= '0;
    else if (lowCnt != LW'(TRP)) lowCnt <= lowCnt + 1'b1;
  end

  assign qualify = syncLow && (lowCnt == LW'(TRP - 1));

  // cycles since the synchronised falling edge, loaded at qualification
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readyCnt <= RW'(TREADY);
    else if (strobe.capture) readyCnt <= RW'(TRP);
    else if (readyCnt != RW'(TREADY)) readyCnt <= readyCnt + 1'b1;
  end

  assign readyDone = (readyCnt == RW'(TREADY));

  // post-release recovery count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recCnt <= '0;
    else if (strobe.clrRec) recCnt <= '0;
    else if (recCnt != HW'(TRH - 1)) recCnt <= recCnt + 1'b1;
  end

  assign recDone = (recCnt == HW'(TRH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abortOp     <= 1'b0;
      corruptFlag <= 1'b0;
    end else begin
      abortOp <= strobe.capture;
      if (strobe.capture) corruptFlag <= opBusy;
    end
  end

  assign dqOeAllow = ~syncLow;

  // R1: an abort only follows a full-width low pulse
  a_r1_abort_after_width: assert property (@(posedge clk) disable iff (!rst_n)
    abortOp |-> (lowCnt == LW'(TRP)));

  // R2: the abort lasts one cycle
  a_r2_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    abortOp |=> !abortOp);

  // R7: the corrupt flag changes only together with an abort
  a_r7_corrupt_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(corruptFlag) |-> abortOp);
endmodule

// File: rtl/rpc_control.sv
module rpc_control
  import rpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       syncLow,
  input  logic       qualify,
  input  logic       readyDone,
  input  logic       recDone,
  output ctlStrobe_t strobe,
  output logic       smReset,
  output logic       readAllow,
  output logic       readyMasked
);
  rstState_e state, stateNxt;

  always_comb begin
    stateNxt       = state;
    strobe.capture = 1'b0;
    strobe.clrRec  = 1'b0;
    unique case (state)
      ST_IDLE: if (qualify) begin
        stateNxt       = ST_HELD;
        strobe.capture = 1'b1;
      end
      ST_HELD: if (!syncLow) begin
        stateNxt      = ST_RECOVER;
        strobe.clrRec = 1'b1;
      end
      ST_RECOVER: begin
        if (syncLow) stateNxt = ST_HELD;
        else if (recDone && readyDone) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else state <= stateNxt;
  end

  assign smReset     = (state != ST_IDLE) && !readyDone;
  assign readAllow   = (state == ST_IDLE) && !syncLow;
  assign readyMasked = syncLow || smReset;

  // R5: reads never open while held
  a_r5_recover_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER) |-> $past(!syncLow));
endmodule

// File: rtl/rst_pulse_ctl.sv
module rst_pulse_ctl
  import rpc_pkg::*;
#(
  parameter int TRP    = 4,
  parameter int TREADY = 10,
  parameter int TRH    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic resetPinN,
  input  logic opBusy,
  output logic abortOp,
  output logic smReset,
  output logic dqOeAllow,
  output logic readAllow,
  output logic readyMasked,
  output logic corruptFlag
);
  ctlStrobe_t strobe;
  logic syncLow, qualify, readyDone, recDone;

  rpc_datapath #(.TRP(TRP), .TREADY(TREADY), .TRH(TRH), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rst_n(rst_n), .resetPinN(resetPinN), .opBusy(opBusy),
    .strobe(strobe), .syncLow(syncLow), .qualify(qualify),
    .readyDone(readyDone), .recDone(recDone), .abortOp(abortOp),
    .corruptFlag(corruptFlag), .dqOeAllow(dqOeAllow)
  );

  rpc_control u_ctl (
    .clk(clk), .rst_n(rst_n), .syncLow(syncLow), .qualify(qualify),
    .readyDone(readyDone), .recDone(recDone), .strobe(strobe),
    .smReset(smReset), .readAllow(readAllow), .readyMasked(readyMasked)
  );

  // R3: the machine is in reset whenever an abort is issued
  a_r3_abort_with_smreset: assert property (@(posedge clk) disable iff (!rst_n)
    abortOp |-> smReset);

  // R5: no read access during an abort
  a_r5_abort_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    abortOp |-> !readAllow);

  // R6: ready/busy masked while outputs are off
  a_r6_mask_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !dqOeAllow |-> readyMasked);
endmodule

// File: tb/sim_rst_pulse_ctl.sv
module sim_rst_pulse_ctl;
  localparam int TRP = 4, TREADY = 10, TRH = 6;
  localparam int S_ABORT = 0, S_SMR = 1, S_OE = 2, S_RD = 3, S_MASK = 4, S_CORR = 5;

  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string req;
  } item_t;

  logic clk = 0, rst_n = 0, resetPinN = 1, opBusy = 0;
  logic abortOp, smReset, dqOeAllow, readAllow, readyMasked, corruptFlag;
  int cyc = 0, checks = 0, errors = 0;
  bit corrModel = 0;
  item_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_pulse_ctl #(.TRP(TRP), .TREADY(TREADY), .TRH(TRH)) u0 (
    .clk(clk), .rst_n(rst_n), .resetPinN(resetPinN), .opBusy(opBusy),
    .abortOp(abortOp), .smReset(smReset), .dqOeAllow(dqOeAllow),
    .readAllow(readAllow), .readyMasked(readyMasked), .corruptFlag(corruptFlag)
  );

  function automatic bit getSig(int s);
    case (s)
      S_ABORT: return abortOp;
      S_SMR:   return smReset;
      S_OE:    return dqOeAllow;
      S_RD:    return readAllow;
      S_MASK:  return readyMasked;
      default: return corruptFlag;
    endcase
  endfunction

  task automatic check(string req, string name, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", req, name, act, exp, $time);
    end
  endtask

  // driver side: sorted insertion into the scoreboard
  task automatic expect_at(int c, int s, bit v, string req);
    item_t it;
    int pos;
    it.cyc = c; it.sig = s; it.val = v; it.req = req;
    pos = expQ.size();
    for (int i = 0; i < expQ.size(); i++)
      if (expQ[i].cyc > c) begin pos = i; break; end
    expQ.insert(pos, it);
  endtask

  // monitor: pop and compare items due in the current cycle
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
        item_t it;
        it = expQ.pop_front();
        check(it.req, $sformatf("sig%0d@%0d", it.sig, it.cyc), getSig(it.sig), it.val);
      end
    end
  end

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic pulse(int lowLen, bit busy);
    int c, x;
    bit qual;
    @(negedge clk); #1;
    c = cyc;
    qual = (lowLen >= TRP);
    expect_at(c + 2, S_OE, 1'b0, "R4");
    expect_at(c + 2, S_MASK, 1'b1, "R6");
    expect_at(c + lowLen + 1, S_OE, 1'b0, "R4");
    expect_at(c + lowLen + 2, S_OE, 1'b1, "R4");
    if (qual) begin
      x = maxi(lowLen + 1 + TRH + 2, TREADY + 3);
      expect_at(c + TRP + 1, S_ABORT, 1'b0, "R1");
      expect_at(c + TRP + 2, S_ABORT, 1'b1, "R2");
      expect_at(c + TRP + 3, S_ABORT, 1'b0, "R2");
      expect_at(c + TRP + 1, S_SMR, 1'b0, "R3");
      expect_at(c + TRP + 2, S_SMR, 1'b1, "R3");
      expect_at(c + TREADY + 1, S_SMR, 1'b1, "R3");
      expect_at(c + TREADY + 2, S_SMR, 1'b0, "R3");
      expect_at(c + TREADY + 1, S_MASK, 1'b1, "R6");
      expect_at(c + TRP + 2, S_CORR, busy, "R7");
      expect_at(c + x - 1, S_RD, 1'b0, "R5");
      expect_at(c + x, S_RD, 1'b1, "R5");
      corrModel = busy;
    end else begin
      x = lowLen + 5;
      expect_at(c + TRP + 2, S_ABORT, 1'b0, "R8");
      expect_at(c + lowLen + 2, S_RD, 1'b1, "R8");
      expect_at(c + lowLen + 3, S_CORR, corrModel, "R8");
      expect_at(c + lowLen + 3, S_SMR, 1'b0, "R8");
    end
    opBusy = busy;
    resetPinN = 0;
    repeat (lowLen) @(negedge clk);
    #1 resetPinN = 1;
    while (cyc < c + x + 3) @(negedge clk);
    opBusy = 0;
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R9", "readAllow", readAllow, 1'b1);
        check("R9", "dqOeAllow", dqOeAllow, 1'b1);
        check("R9", "abortOp", abortOp, 1'b0);
        check("R9", "smReset", smReset, 1'b0);
        check("R9", "readyMasked", readyMasked, 1'b0);
        check("R9", "corruptFlag", corruptFlag, 1'b0);
        pulse(TRP - 1, 1'b1);  // R8 boundary: one short
        pulse(TRP, 1'b1);      // R1 boundary: exactly TRP
        pulse(20, 1'b0);       // long pulse, recovery count dominates
        pulse(1, 1'b1);        // R8: glitch
        pulse(12, 1'b1);       // mid-length, busy
        pulse(TRP - 2, 1'b0);  // R8 again
        repeat (3) @(negedge clk);
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          errors++;
          checks++;
          $display("FAIL watchdog expired actual=hung expected=done");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule